// File: doc/BRIEF.md
# Second-Operand Barrel Shifter

This unit forms the second operand of a 32-bit data-processing instruction and the carry that the shifter hands to the flag logic. It looks at the instruction word, the value read from the shifted source register (Rm), the low byte of the amount register (Rs) and the current carry flag. It returns either a rotated 8-bit immediate or a shifted copy of Rm. It covers all of the architectural corner encodings: a zero immediate amount that stands for a shift by 32 or for rotate-with-extend, register amounts of 32 and above, and a register rotation whose amount is a multiple of 32.

A second mode serves the index path of loads and stores. In that mode the immediate-form bit is ignored, so the operand always comes from Rm, and only the immediate-amount shift kinds take effect. Both outputs are registered, so a result is visible one clock after its inputs.

Top module: `opshift_unit`

## Requirements
- R1: With the index mode off and instruction bit 25 set, the operand is bits 7:0 zero-extended and rotated right by twice the value in bits 11:8. The carry is operand bit 31 when that field is nonzero, and the incoming carry when it is zero.
- R2: Shift kind 0 in bits 6:4 (left shift by the amount in bits 11:7): for an amount n > 0 the carry is Rm[32-n]. For amount 0, Rm and the incoming carry pass through unchanged.
- R3: Shift kind 2 (logical right by immediate): for n > 0 the carry is Rm[n-1]. An amount of 0 means a shift by 32, which gives an operand of 0 and a carry of Rm[31].
- R4: Shift kind 4 (arithmetic right by immediate): for n > 0 the carry is Rm[n-1]. An amount of 0 gives every bit equal to Rm[31], with a carry of Rm[31].
- R5: Shift kind 6 (rotate right by immediate): for n > 0 the operand rotates right by n and the carry is Rm[n-1]. An amount of 0 shifts right by one place, puts the incoming carry into bit 31, and sets the carry to Rm[0].
- R6: For the odd shift kinds (1, 3, 5, 7), the amount is the Rs low byte. An amount of 0 passes Rm and the incoming carry through unchanged.
- R7: Register left shift (kind 1) and register logical right shift (kind 3): for amounts 1 to 31 the carry is the last bit shifted out. An amount of 32 gives 0 with a carry of Rm[0] for the left shift and Rm[31] for the right shift. Amounts above 32 give 0 with a carry of 0.
- R8: Register arithmetic right shift (kind 5): an amount of 32 or more fills every bit with Rm[31], and the carry is Rm[31].
- R9: Register rotation (kind 7): for a nonzero amount whose low 5 bits are zero, Rm is unchanged and the carry is Rm[31]. Any other nonzero amount rotates by its low 5 bits, and the carry is the new bit 31.
- R10: With the index mode on, bit 25 has no effect and the even kinds behave as in R2 to R5. An odd kind returns Rm and the incoming carry unchanged.
- R11: Outputs change only at a rising clock edge and reflect the inputs sampled at that edge. A synchronous active-high reset clears the operand and the carry to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Instruction word |
| rm_i | input | 32 | Value of the shifted source register |
| rs_lo_i | input | 8 | Low byte of the shift-amount register |
| carry_i | input | 1 | Current carry flag |
| index_mode_i | input | 1 | 1 selects the load/store index variant |
| operand_o | output | 32 | Registered shifted operand |
| carry_o | output | 1 | Registered shifter carry |

## Verification
The hardest cases to reach are the register-amount boundaries: exactly 32, just above 32, and nonzero multiples of 32 for rotation. A uniform random byte rarely lands on these values. The random generator therefore draws the Rs byte from a weighted set that includes 0, 1, 31, 32, 33, 64 and 255, and directed vectors pin each boundary down. Expected results come from a reference model that moves one bit per step in a loop, so every carry rule follows from the last bit moved rather than from a case table.

// File: rtl/opshift_pkg.sv
package opshift_pkg;
  localparam int DATA_W    = 32;
  localparam int RS_AMT_W  = 8;
  localparam int IMM8_W    = 8;
  localparam int ROTF_W    = 4;

  // instruction field positions the decoder depends on
  localparam int IMM_FORM_BIT = 25;
  localparam int KIND_LO      = 4;
  localparam int SHAMT_LO     = 7;
  localparam int ROTF_LO      = 8;

  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shift_op_e;
endpackage

// File: rtl/opshift_rotimm.sv
module opshift_rotimm #(
  parameter int W      = opshift_pkg::DATA_W,
  parameter int IMM_W  = opshift_pkg::IMM8_W,
  parameter int ROT_W  = opshift_pkg::ROTF_W
) (
  input  logic [IMM_W-1:0] imm_i,
  input  logic [ROT_W-1:0] rot_i,
  input  logic             cin_i,
  output logic [W-1:0]     res_o,
  output logic             cout_o
);
  localparam int AMT_W = ROT_W + 1;

  logic [W-1:0]     base;
  logic [AMT_W-1:0] amt;

  always_comb begin
    base   = {{(W-IMM_W){1'b0}}, imm_i};
    amt    = {rot_i, 1'b0};
    res_o  = (base >> amt) | (base << (W - int'(amt)));
    cout_o = (rot_i == '0) ? cin_i : res_o[W-1];
  end
endmodule

// File: rtl/opshift_immsh.sv
module opshift_immsh
  import opshift_pkg::*;
#(
  parameter int W    = DATA_W,
  parameter int SH_W = $clog2(W)
) (
  input  shift_op_e       op_i,
  input  logic [SH_W-1:0] amt_i,
  input  logic [W-1:0]    rm_i,
  input  logic            cin_i,
  output logic [W-1:0]    res_o,
  output logic            cout_o
);
  logic [W:0]        ext_l;
  logic [W:0]        ext_r;
  logic signed [W:0] ext_a;
  logic [W-1:0]      rot;
  logic              zero_amt;

  always_comb begin
    zero_amt = (amt_i == '0);
    ext_l    = {1'b0, rm_i} << amt_i;
    ext_r    = {rm_i, 1'b0} >> amt_i;
    ext_a    = $signed({rm_i, 1'b0}) >>> amt_i;
    rot      = (rm_i >> amt_i) | (rm_i << (W - int'(amt_i)));
    res_o    = rm_i;
    cout_o   = cin_i;
    unique case (op_i)
      SH_LSL: begin
        if (!zero_amt) begin
          res_o  = ext_l[W-1:0];
          cout_o = ext_l[W];
        end
      end
      SH_LSR: begin
        if (zero_amt) begin
          res_o  = '0;
          cout_o = rm_i[W-1];
        end else begin
          res_o  = ext_r[W:1];
          cout_o = ext_r[0];
        end
      end
      SH_ASR: begin
        if (zero_amt) begin
          res_o  = {W{rm_i[W-1]}};
          cout_o = rm_i[W-1];
        end else begin
          res_o  = ext_a[W:1];
          cout_o = ext_a[0];
        end
      end
      SH_ROR: begin
        if (zero_amt) begin
          res_o  = {cin_i, rm_i[W-1:1]};
          cout_o = rm_i[0];
        end else begin
          res_o  = rot;
          cout_o = rot[W-1];
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/opshift_regsh.sv
module opshift_regsh
  import opshift_pkg::*;
#(
  parameter int W     = DATA_W,
  parameter int AMT_W = RS_AMT_W,
  parameter int SH_W  = $clog2(W)
) (
  input  shift_op_e        op_i,
  input  logic [AMT_W-1:0] amt_i,
  input  logic [W-1:0]     rm_i,
  input  logic             cin_i,
  output logic [W-1:0]     res_o,
  output logic             cout_o
);
  logic [SH_W-1:0]   lo;
  logic              zero_amt, in_range, at_width;
  logic [W:0]        ext_l;
  logic [W:0]        ext_r;
  logic signed [W:0] ext_a;
  logic [W-1:0]      rot;

  always_comb begin
    lo       = amt_i[SH_W-1:0];
    zero_amt = (amt_i == '0);
    in_range = (int'(amt_i) < W);
    at_width = (int'(amt_i) == W);
    ext_l    = {1'b0, rm_i} << lo;
    ext_r    = {rm_i, 1'b0} >> lo;
    ext_a    = $signed({rm_i, 1'b0}) >>> lo;
    rot      = (rm_i >> lo) | (rm_i << (W - int'(lo)));
    res_o    = rm_i;
    cout_o   = cin_i;
    if (!zero_amt) begin
      unique case (op_i)
        SH_LSL: begin
          if (in_range) begin
            res_o  = ext_l[W-1:0];
            cout_o = ext_l[W];
          end else begin
            res_o  = '0;
            cout_o = at_width ? rm_i[0] : 1'b0;
          end
        end
        SH_LSR: begin
          if (in_range) begin
            res_o  = ext_r[W:1];
            cout_o = ext_r[0];
          end else begin
            res_o  = '0;
            cout_o = at_width ? rm_i[W-1] : 1'b0;
          end
        end
        SH_ASR: begin
          if (in_range) begin
            res_o  = ext_a[W:1];
            cout_o = ext_a[0];
          end else begin
            res_o  = {W{rm_i[W-1]}};
            cout_o = rm_i[W-1];
          end
        end
        SH_ROR: begin
          if (lo == '0) begin
            res_o  = rm_i;
            cout_o = rm_i[W-1];
          end else begin
            res_o  = rot;
            cout_o = rot[W-1];
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/opshift_unit.sv
module opshift_unit
  import opshift_pkg::*;
#(
  parameter int W      = DATA_W,
  parameter int AMT_W  = RS_AMT_W,
  parameter int IMM_W  = IMM8_W,
  parameter int ROT_W  = ROTF_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [31:0]      instr_i,
  input  logic [W-1:0]     rm_i,
  input  logic [AMT_W-1:0] rs_lo_i,
  input  logic             carry_i,
  input  logic             index_mode_i,
  output logic [W-1:0]     operand_o,
  output logic             carry_o
);
  localparam int SH_W = $clog2(W);

  shift_op_e        op;
  logic             reg_kind;
  logic [SH_W-1:0]  sh_amt;
  logic [W-1:0]     rot_res, imm_res, reg_res, nxt_res;
  logic             rot_c, imm_c, reg_c, nxt_c;
  logic             use_rotimm;
  logic             primed_q;

  always_comb begin
    op         = shift_op_e'(instr_i[KIND_LO+2 -: 2]);
    reg_kind   = instr_i[KIND_LO];
    sh_amt     = instr_i[SHAMT_LO +: SH_W];
    use_rotimm = !index_mode_i && instr_i[IMM_FORM_BIT];
  end

  opshift_rotimm #(.W(W), .IMM_W(IMM_W), .ROT_W(ROT_W)) u_rot (
    .imm_i  (instr_i[IMM_W-1:0]),
    .rot_i  (instr_i[ROTF_LO +: ROT_W]),
    .cin_i  (carry_i),
    .res_o  (rot_res),
    .cout_o (rot_c)
  );

  opshift_immsh #(.W(W), .SH_W(SH_W)) u_imm (
    .op_i   (op),
    .amt_i  (sh_amt),
    .rm_i   (rm_i),
    .cin_i  (carry_i),
    .res_o  (imm_res),
    .cout_o (imm_c)
  );

  opshift_regsh #(.W(W), .AMT_W(AMT_W), .SH_W(SH_W)) u_reg (
    .op_i   (op),
    .amt_i  (rs_lo_i),
    .rm_i   (rm_i),
    .cin_i  (carry_i),
    .res_o  (reg_res),
    .cout_o (reg_c)
  );

  always_comb begin
    if (use_rotimm) begin
      nxt_res = rot_res;
      nxt_c   = rot_c;
    end else if (!reg_kind) begin
      nxt_res = imm_res;
      nxt_c   = imm_c;
    end else if (index_mode_i) begin
      nxt_res = rm_i;
      nxt_c   = carry_i;
    end else begin
      nxt_res = reg_res;
      nxt_c   = reg_c;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      operand_o <= '0;
      carry_o   <= 1'b0;
      primed_q  <= 1'b0;
    end else begin
      operand_o <= nxt_res;
      carry_o   <= nxt_c;
      primed_q  <= 1'b1;
    end
  end

  // R1: zero rotation field returns the plain byte and the incoming carry
  a_r1_rot_zero: assert property (@(posedge clk) disable iff (rst)
    primed_q && $past(!index_mode_i && instr_i[IMM_FORM_BIT] && instr_i[ROTF_LO +: ROT_W] == '0)
    |-> operand_o == $past({{(W-IMM_W){1'b0}}, instr_i[IMM_W-1:0]}) && carry_o == $past(carry_i));

  // R3: immediate logical right by 0 acts as a shift by the full width
  a_r3_lsr_full: assert property (@(posedge clk) disable iff (rst)
    primed_q && $past(!use_rotimm && instr_i[KIND_LO+2:KIND_LO] == 3'd2 && instr_i[SHAMT_LO +: SH_W] == '0)
    |-> operand_o == '0 && carry_o == $past(rm_i[W-1]));

  // R6: register amount of zero is a pass-through
  a_r6_reg_zero: assert property (@(posedge clk) disable iff (rst)
    primed_q && $past(!index_mode_i && !instr_i[IMM_FORM_BIT] && instr_i[KIND_LO] && rs_lo_i == '0)
    |-> operand_o == $past(rm_i) && carry_o == $past(carry_i));

  // R7: register logical shifts beyond the width clear operand and carry
  a_r7_over_width: assert property (@(posedge clk) disable iff (rst)
    primed_q && $past(!index_mode_i && !instr_i[IMM_FORM_BIT] && instr_i[KIND_LO]
                      && !instr_i[KIND_LO+2] && int'(rs_lo_i) > W)
    |-> operand_o == '0 && carry_o == 1'b0);

  // R10: index mode never applies a register amount
  a_r10_index_reg: assert property (@(posedge clk) disable iff (rst)
    primed_q && $past(index_mode_i && instr_i[KIND_LO])
    |-> operand_o == $past(rm_i) && carry_o == $past(carry_i));
endmodule

// File: tb/opshift_unit_test.sv
module opshift_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr_i = '0;
  logic [31:0] rm_i = '0;
  logic [7:0]  rs_lo_i = '0;
  logic        carry_i = 1'b0;
  logic        index_mode_i = 1'b0;
  logic [31:0] operand_o;
  logic        carry_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 1'b0;

  opshift_unit uut (
    .clk(clk), .rst(rst), .instr_i(instr_i), .rm_i(rm_i), .rs_lo_i(rs_lo_i),
    .carry_i(carry_i), .index_mode_i(index_mode_i),
    .operand_o(operand_o), .carry_o(carry_o)
  );

  always #5 clk = ~clk;

  // reference: move one bit per step, carry is the last bit moved out
  function automatic logic [32:0] model(input logic [31:0] ir, input logic [31:0] rm,
                                        input logic [7:0] rs, input logic c, input logic idx);
    logic [31:0] r;
    logic        co;
    int          n;
    logic [2:0]  k;
    r  = rm;
    co = c;
    k  = ir[6:4];
    if (!idx && ir[25]) begin
      r = {24'd0, ir[7:0]};
      for (int i = 0; i < 2 * int'(ir[11:8]); i++) r = {r[0], r[31:1]};
      co = (ir[11:8] != 0) ? r[31] : c;
      return {co, r};
    end
    if (idx && k[0]) return {c, rm};
    if (!k[0]) begin
      n = int'(ir[11:7]);
      if (n == 0) begin
        case (k)
          3'd2, 3'd4: n = 32;
          3'd6: return {rm[0], c, rm[31:1]};
          default: return {c, rm};
        endcase
      end
    end else begin
      n = int'(rs);
    end
    for (int i = 0; i < n; i++) begin
      case (k[2:1])
        2'd0: begin co = r[31]; r = {r[30:0], 1'b0}; end
        2'd1: begin co = r[0];  r = {1'b0, r[31:1]}; end
        2'd2: begin co = r[0];  r = {r[31], r[31:1]}; end
        default: begin co = r[0]; r = {r[0], r[31:1]}; end
      endcase
    end
    return {co, r};
  endfunction

  function automatic string req_of(input logic [31:0] ir, input logic idx);
    if (!idx && ir[25]) return "R1";
    if (idx && ir[4]) return "R10";
    case (ir[6:4])
      3'd0: return "R2";
      3'd2: return "R3";
      3'd4: return "R4";
      3'd6: return "R5";
      3'd1, 3'd3: return (ir[25] == 1'b0) ? "R7" : "R7";
      3'd5: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] got_v, input logic got_c,
                       input logic [31:0] exp_v, input logic exp_c);
    n_tests++;
    if (got_v !== exp_v || got_c !== exp_c) begin
      n_fail++;
      $display("FAIL %s: got operand=%08h carry=%0b, expected operand=%08h carry=%0b",
               req, got_v, got_c, exp_v, exp_c);
    end
  endtask

  // drive at a falling edge, result is registered at the next rising edge
  task automatic run(input string req, input logic [31:0] ir, input logic [31:0] rm,
                     input logic [7:0] rs, input logic c, input logic idx,
                     input logic [31:0] exp_v, input logic exp_c);
    instr_i = ir; rm_i = rm; rs_lo_i = rs; carry_i = c; index_mode_i = idx;
    @(negedge clk);
    check(req, operand_o, carry_o, exp_v, exp_c);
  endtask

  task automatic run_model(input string req, input logic [31:0] ir, input logic [31:0] rm,
                           input logic [7:0] rs, input logic c, input logic idx);
    logic [32:0] e;
    e = model(ir, rm, rs, c, idx);
    run(req, ir, rm, rs, c, idx, e[31:0], e[32]);
  endtask

  function automatic logic [31:0] imm_ir(input logic [2:0] k, input logic [4:0] n);
    return ({27'd0, n} << 7) | ({29'd0, k} << 4);
  endfunction

  function automatic logic [31:0] rot_ir(input logic [3:0] rot, input logic [7:0] v);
    return 32'h0200_0000 | ({28'd0, rot} << 8) | {24'd0, v};
  endfunction

  function automatic logic [7:0] pick_amt();
    case ($urandom % 10)
      0: return 8'd0;
      1: return 8'd1;
      2: return 8'd31;
      3: return 8'd32;
      4: return 8'd33;
      5: return 8'd64;
      6: return 8'd255;
      default: return 8'($urandom);
    endcase
  endfunction

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1;
    rm_i = 32'hFFFF_FFFF; carry_i = 1'b1;
    repeat (3) @(negedge clk);
    check("R11", operand_o, carry_o, 32'h0, 1'b0);   // R11 reset state
    rst = 1'b0;

    // R1 rotated immediate
    run("R1", rot_ir(4'd4, 8'hFF), 32'h0, 8'd0, 1'b0, 1'b0, 32'hFF00_0000, 1'b1);
    run("R1", rot_ir(4'd0, 8'hFF), 32'h0, 8'd0, 1'b1, 1'b0, 32'h0000_00FF, 1'b1);
    run("R1", rot_ir(4'd1, 8'h01), 32'h0, 8'd0, 1'b1, 1'b0, 32'h4000_0000, 1'b0);
    // R2 left by immediate
    run("R2", imm_ir(3'd0, 5'd0), 32'h8000_0001, 8'd0, 1'b1, 1'b0, 32'h8000_0001, 1'b1);
    run("R2", imm_ir(3'd0, 5'd1), 32'h8000_0001, 8'd0, 1'b0, 1'b0, 32'h0000_0002, 1'b1);
    // R3 logical right by immediate 0 = by 32
    run("R3", imm_ir(3'd2, 5'd0), 32'h8000_0000, 8'd0, 1'b0, 1'b0, 32'h0, 1'b1);
    run("R3", imm_ir(3'd2, 5'd4), 32'h0000_00F8, 8'd0, 1'b0, 1'b0, 32'h0000_000F, 1'b1);
    // R4 arithmetic right by immediate
    run("R4", imm_ir(3'd4, 5'd0), 32'h8000_0000, 8'd0, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b1);
    run("R4", imm_ir(3'd4, 5'd0), 32'h7FFF_FFFF, 8'd0, 1'b1, 1'b0, 32'h0, 1'b0);
    // R5 rotate-with-extend and plain rotate
    run("R5", imm_ir(3'd6, 5'd0), 32'h0000_0001, 8'd0, 1'b1, 1'b0, 32'h8000_0000, 1'b1);
    run("R5", imm_ir(3'd6, 5'd8), 32'h0000_0012, 8'd0, 1'b0, 1'b0, 32'h1200_0000, 1'b0);
    // R6 register amount zero
    run("R6", imm_ir(3'd3, 5'd0), 32'hDEAD_BEEF, 8'd0, 1'b1, 1'b0, 32'hDEAD_BEEF, 1'b1);
    run("R6", imm_ir(3'd7, 5'd0), 32'h1234_5678, 8'd0, 1'b0, 1'b0, 32'h1234_5678, 1'b0);
    // R7 register logical shifts at and beyond 32
    run("R7", imm_ir(3'd1, 5'd0), 32'h0000_0001, 8'd32, 1'b0, 1'b0, 32'h0, 1'b1);
    run("R7", imm_ir(3'd3, 5'd0), 32'h8000_0000, 8'd32, 1'b0, 1'b0, 32'h0, 1'b1);
    run("R7", imm_ir(3'd3, 5'd0), 32'hFFFF_FFFF, 8'd33, 1'b1, 1'b0, 32'h0, 1'b0);
    run("R7", imm_ir(3'd1, 5'd0), 32'hFFFF_FFFF, 8'd200, 1'b1, 1'b0, 32'h0, 1'b0);
    // R8 register arithmetic right beyond width
    run("R8", imm_ir(3'd5, 5'd0), 32'h8000_0000, 8'd40, 1'b0, 1'b0, 32'hFFFF_FFFF, 1'b1);
    // R9 register rotate
    run("R9", imm_ir(3'd7, 5'd0), 32'h8000_0000, 8'd32, 1'b0, 1'b0, 32'h8000_0000, 1'b1);
    run("R9", imm_ir(3'd7, 5'd0), 32'h0000_000F, 8'd36, 1'b0, 1'b0, 32'hF000_0000, 1'b1);
    // R10 index mode: bit 25 ignored, register kinds pass through
    run("R10", imm_ir(3'd0, 5'd4) | 32'h0200_0000, 32'h1, 8'd0, 1'b0, 1'b1, 32'h10, 1'b0);
    run("R10", imm_ir(3'd3, 5'd0), 32'hCAFE_F00D, 8'd8, 1'b1, 1'b1, 32'hCAFE_F00D, 1'b1);

    // R11: output holds until the next rising edge
    instr_i = imm_ir(3'd0, 5'd0); rm_i = 32'h5555_0000; carry_i = 1'b0; index_mode_i = 1'b0;
    #1;
    check("R11", operand_o, carry_o, 32'hCAFE_F00D, 1'b1);
    @(negedge clk);
    check("R11", operand_o, carry_o, 32'h5555_0000, 1'b0);

    // random sweep against the bit-serial model
    for (int t = 0; t < 4000; t++) begin
      logic [31:0] ir;
      logic        idx;
      ir  = $urandom;
      idx = (($urandom % 4) == 0);
      if (($urandom % 3) == 0) ir[11:7] = 5'd0;
      run_model(req_of(ir, idx), ir, $urandom, pick_amt(), 1'($urandom), idx);
    end

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule